// File: doc/BRIEF.md
# Guarded Power-Saving Mode Controller

This block holds the power-control register of a small 8-bit microcontroller core. The register sits at one special-function address. Through it, software enters idle mode, which stops the CPU clock, or power-down mode, which also stops the oscillator. Software can also reach a baud-rate doubling bit and two general-purpose flags in the same register.

Entry to a mode is guarded in three ways. First, a mode is armed by one bit in one write, and it is entered only if the very next SFR write sets the matching second bit. Second, both writes must happen while the external enable pin allows power saving. Third, any other write in between, or the enable pin dropping, cancels the armed state.

Idle ends when an interrupt request arrives. The flags and the baud bit keep their values through idle, so the handler can read them. Power-down ends only on reset.

Top module: `pwr_save_ctrl`

## Requirements
- R1: After reset all outputs are 0 and the register reads back 0x00.
- R2: Bit 7 (baud doubling), bit 3 (flag 1) and bit 2 (flag 0) are plain read/write bits. They appear on `baud_dbl` and `gflag`. Bits 6, 5 and 4 always read back 0.
- R3: A write to address 0x87 with bit 1 = 1 and bit 6 = 0 arms power-down. If the next SFR write sets bit 6, then one cycle after that write `pdown_active`, `osc_stop` and `cpu_clk_stop` are 1.
- R4: A write with bit 0 = 1 and bit 5 = 0 arms idle. If the next SFR write sets bit 5, then one cycle later `idle_active` and `cpu_clk_stop` are 1 and `osc_stop` stays 0.
- R5: Setting only the second bit of a pair never enters a mode. A write that sets both bits of a pair neither arms nor enters that mode.
- R6: Any SFR write other than the entering write cancels the armed state. This includes a write to another address.
- R7: While `save_en` is 0, writes neither arm nor enter a mode, and an armed state is cleared.
- R8: Idle ends one cycle after `irq_req` is 1. Flags written by the entering write stay as written, and the baud bit is unchanged.
- R9: Power-down ignores `irq_req` and stays active until reset.
- R10: While a mode is active, SFR writes have no effect on the register.
- R11: Reading the register shows the power-down armed state in bit 1 and the idle armed state in bit 0.
- R12: If one write enters both armed modes, only power-down starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Register readback, 0 when the address does not match |
| save_en | input | 1 | Enable pin; 1 allows power-saving modes |
| irq_req | input | 1 | Enabled interrupt request |
| idle_active | output | 1 | Idle mode status |
| pdown_active | output | 1 | Power-down mode status |
| cpu_clk_stop | output | 1 | Request to gate the CPU clock |
| osc_stop | output | 1 | Request to stop the oscillator |
| baud_dbl | output | 1 | Baud-rate doubling bit |
| gflag | output | 2 | General-purpose flags {flag1, flag0} |

## Verification
The assertions check on every cycle that:
- power-down never drops on its own;
- the two modes are never active together;
- a low enable pin leaves nothing armed;
- a mode only rises right after an armed state;
- flags are frozen while idle;
- an interrupt during idle ends it.

Only the bench's scenarios can show the exact two-write ordering through to each mode's outputs. They also show that single bits, combined bits and intervening writes fail to enter, that readback values are correct, and that power-down is left only by reset.

// File: rtl/pwr_save_pkg.sv
package pwr_save_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_PAIRS = 2;
  localparam int unsigned PAIR_PD = 0;
  localparam int unsigned PAIR_IDL = 1;

  localparam int unsigned B_IDL_ARM = 0;
  localparam int unsigned B_PD_ARM = 1;
  localparam int unsigned B_GF0 = 2;
  localparam int unsigned B_GF1 = 3;
  localparam int unsigned B_IDL_GO = 5;
  localparam int unsigned B_PD_GO = 6;
  localparam int unsigned B_BAUD = 7;

  function automatic int unsigned first_pos(int unsigned pair);
    return (pair == PAIR_PD) ? B_PD_ARM : B_IDL_ARM;
  endfunction

  function automatic int unsigned second_pos(int unsigned pair);
    return (pair == PAIR_PD) ? B_PD_GO : B_IDL_GO;
  endfunction

  function automatic logic arm_next(logic first_b, logic second_b, logic en);
    return en & first_b & ~second_b;
  endfunction

  function automatic logic enter_now(logic armed, logic second_b, logic en);
    return en & armed & second_b;
  endfunction

  function automatic logic [DATA_W-1:0] pack_rb(logic baud, logic [1:0] gf,
                                                logic pd_arm, logic idl_arm);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_BAUD] = baud;
    v[B_GF1] = gf[1];
    v[B_GF0] = gf[0];
    v[B_PD_ARM] = pd_arm;
    v[B_IDL_ARM] = idl_arm;
    return v;
  endfunction
endpackage

// File: rtl/pwr_arm_stage.sv
module pwr_arm_stage
  import pwr_save_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_any,
  input  logic wr_hit,
  input  logic first_b,
  input  logic second_b,
  input  logic save_en,
  output logic armed,
  output logic enter
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (!save_en) armed_q <= 1'b0;
    else if (wr_any) armed_q <= wr_hit ? arm_next(first_b, second_b, save_en) : 1'b0;
  end

  assign armed = armed_q;
  assign enter = wr_hit & enter_now(armed_q, second_b, save_en);

  AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> !armed_q); // R7
  AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !wr_hit) |=> !armed_q); // R6
endmodule

// File: rtl/pwr_mode_state.sv
module pwr_mode_state (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_pd,
  input  logic enter_idl,
  input  logic irq_req,
  output logic idle_q,
  output logic pd_q
);
  logic idle_r, pd_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_r <= 1'b0;
      pd_r   <= 1'b0;
    end else begin
      if (enter_pd) pd_r <= 1'b1;
      if (enter_pd) idle_r <= 1'b0;
      else if (enter_idl) idle_r <= 1'b1;
      else if (irq_req) idle_r <= 1'b0;
    end
  end

  assign idle_q = idle_r;
  assign pd_q   = pd_r;

  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pd_r |=> pd_r); // R9
  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_r && idle_r)); // R12
endmodule

// File: rtl/pwr_flag_reg.sv
module pwr_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       baud_in,
  input  logic [1:0] gf_in,
  output logic       baud_q,
  output logic [1:0] gf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= 1'b0;
      gf_q   <= 2'b00;
    end else if (wr_hit) begin
      baud_q <= baud_in;
      gf_q   <= gf_in;
    end
  end
endmodule

// File: rtl/pwr_save_ctrl.sv
module pwr_save_ctrl
  import pwr_save_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       save_en,
  input  logic       irq_req,
  output logic       idle_active,
  output logic       pdown_active,
  output logic       cpu_clk_stop,
  output logic       osc_stop,
  output logic       baud_dbl,
  output logic [1:0] gflag
);
  logic in_mode, wr_ok, wr_hit, addr_match;
  logic [N_PAIRS-1:0] armed, enter;
  logic idle_q, pd_q, baud_q;
  logic [1:0] gf_q;
  logic unused_bit4;

  assign unused_bit4 = sfr_wdata[4];
  assign in_mode    = idle_q | pd_q;
  assign addr_match = (sfr_addr == REG_ADDR);
  assign wr_ok      = sfr_wr & ~in_mode;
  assign wr_hit     = wr_ok & addr_match;

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    pwr_arm_stage u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_any   (wr_ok),
      .wr_hit   (wr_hit),
      .first_b  (sfr_wdata[first_pos(g)]),
      .second_b (sfr_wdata[second_pos(g)]),
      .save_en  (save_en),
      .armed    (armed[g]),
      .enter    (enter[g])
    );
  end

  pwr_mode_state u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_pd  (enter[PAIR_PD]),
    .enter_idl (enter[PAIR_IDL]),
    .irq_req   (irq_req),
    .idle_q    (idle_q),
    .pd_q      (pd_q)
  );

  pwr_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .baud_in (sfr_wdata[B_BAUD]),
    .gf_in   ({sfr_wdata[B_GF1], sfr_wdata[B_GF0]}),
    .baud_q  (baud_q),
    .gf_q    (gf_q)
  );

  assign sfr_rdata    = addr_match ? pack_rb(baud_q, gf_q, armed[PAIR_PD], armed[PAIR_IDL]) : '0;
  assign idle_active  = idle_q;
  assign pdown_active = pd_q;
  assign cpu_clk_stop = idle_q | pd_q;
  assign osc_stop     = pd_q;
  assign baud_dbl     = baud_q;
  assign gflag        = gf_q;

  AST_PD_RISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdown_active) |-> $past(armed[PAIR_PD] && sfr_wr && save_en)); // R3
  AST_IDLE_RISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_active) |-> $past(armed[PAIR_IDL] && sfr_wr && save_en)); // R4
  AST_IDLE_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && irq_req) |=> !idle_active); // R8
  AST_FROZEN_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_stop |=> ($stable(gflag) && $stable(baud_dbl))); // R10
endmodule

// File: tb/pwr_save_ctrl_tb.sv
module pwr_save_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h87;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic save_en = 1'b1;
  logic irq_req = 1'b0;
  logic idle_active, pdown_active, cpu_clk_stop, osc_stop, baud_dbl;
  logic [1:0] gflag;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwr_save_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .save_en(save_en),
    .irq_req(irq_req), .idle_active(idle_active), .pdown_active(pdown_active),
    .cpu_clk_stop(cpu_clk_stop), .osc_stop(osc_stop), .baud_dbl(baud_dbl),
    .gflag(gflag)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st();
    return {4'b0, idle_active, pdown_active, cpu_clk_stop, osc_stop};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sfr_wr = 1'b0; irq_req = 1'b0; save_en = 1'b1; sfr_addr = 8'h87;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = 8'h87;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", st(), 8'h00);
    chk("R1 readback", sfr_rdata, 8'h00);
    chk("R1 baud/flags", {5'b0, baud_dbl, gflag}, 8'h00);
  endtask

  task automatic t_plain();
    do_reset();
    wr(8'h87, 8'hFC);
    chk("R2 readback", sfr_rdata, 8'h8C);
    chk("R2 outputs", {5'b0, baud_dbl, gflag}, 8'h07);
    chk("R2 no mode", st(), 8'h00);
    wr(8'h87, 8'h04);
    chk("R2 rewrite", sfr_rdata, 8'h04);
    sfr_addr = 8'h88; #1;
    chk("R2 other addr reads 0", sfr_rdata, 8'h00);
    sfr_addr = 8'h87;
  endtask

  task automatic t_arm_rb();
    do_reset();
    wr(8'h87, 8'h02);
    chk("R11 pd armed", sfr_rdata, 8'h02);
    wr(8'h87, 8'h01);
    chk("R11 idle armed", sfr_rdata, 8'h01);
  endtask

  task automatic t_idle();
    do_reset();
    wr(8'h87, 8'h81);
    wr(8'h87, 8'hAC);
    chk("R4 idle entered", st(), 8'h0A);
    chk("R8 flags from entry write", {5'b0, baud_dbl, gflag}, 8'h07);
    wr(8'h87, 8'h00);
    chk("R10 write ignored in idle", {5'b0, baud_dbl, gflag}, 8'h07);
    @(negedge clk);
    chk("R8 idle holds without irq", st(), 8'h0A);
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R8 idle exited", st(), 8'h00);
    chk("R8 flags kept", {5'b0, baud_dbl, gflag}, 8'h07);
  endtask

  task automatic t_pd();
    do_reset();
    wr(8'h87, 8'h02);
    wr(8'h87, 8'h48);
    chk("R3 power-down entered", st(), 8'h07);
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    irq_req = 1'b0;
    chk("R9 irq ignored", st(), 8'h07);
    wr(8'h87, 8'h84);
    chk("R10 write ignored in pd", {5'b0, baud_dbl, gflag}, 8'h02);
    do_reset();
    chk("R9 reset exits", st(), 8'h00);
  endtask

  task automatic t_single_both();
    do_reset();
    wr(8'h87, 8'h40);
    chk("R5 lone second pd", st(), 8'h00);
    wr(8'h87, 8'h20);
    chk("R5 lone second idle", st(), 8'h00);
    wr(8'h87, 8'h42);
    chk("R5 both bits no arm", sfr_rdata, 8'h00);
    wr(8'h87, 8'h40);
    chk("R5 both bits no entry", st(), 8'h00);
    wr(8'h87, 8'h21);
    wr(8'h87, 8'h20);
    chk("R5 idle pair in one write", st(), 8'h00);
  endtask

  task automatic t_between();
    do_reset();
    wr(8'h87, 8'h02);
    wr(8'h90, 8'h55);
    chk("R6 foreign write disarms", sfr_rdata, 8'h00);
    wr(8'h87, 8'h40);
    chk("R6 no pd after foreign write", st(), 8'h00);
    wr(8'h87, 8'h01);
    wr(8'h87, 8'h80);
    wr(8'h87, 8'h20);
    chk("R6 no idle after other write", st(), 8'h00);
  endtask

  task automatic t_enable();
    do_reset();
    save_en = 1'b0;
    wr(8'h87, 8'h02);
    chk("R7 no arm when disabled", sfr_rdata, 8'h00);
    wr(8'h87, 8'h40);
    chk("R7 no entry when disabled", st(), 8'h00);
    save_en = 1'b1;
    wr(8'h87, 8'h01);
    save_en = 1'b0;
    @(negedge clk);
    save_en = 1'b1;
    chk("R7 drop disarms", sfr_rdata, 8'h00);
    wr(8'h87, 8'h20);
    chk("R7 no idle after drop", st(), 8'h00);
    wr(8'h87, 8'h02);
    save_en = 1'b0;
    wr(8'h87, 8'h40);
    save_en = 1'b1;
    chk("R7 entry write while disabled", st(), 8'h00);
  endtask

  task automatic t_both_enter();
    do_reset();
    wr(8'h87, 8'h03);
    chk("R11 both armed", sfr_rdata, 8'h03);
    wr(8'h87, 8'h60);
    chk("R12 pd wins", st(), 8'h07);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_arm_rb();
    t_idle();
    t_pd();
    t_single_both();
    t_between();
    t_enable();
    t_both_enter();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule